// File: doc/BRIEF.md
# Reduced Associative Preload Tracker

This block keeps registers coherent with memory after the compiler has hoisted a load above stores whose addresses it could not disambiguate. It has a small pool of fully associative entries instead of one address slot per register. Each entry records the address of a hoisted load, the number of the register that load wrote, and a valid flag. Any register can be protected, but only as many at once as there are entries.

A preload allocates an entry, or refreshes the one its register already owns. Every store is compared in parallel against all valid entries. For each match, the tracker names the register to patch and carries the stored data. When several entries match one store, the patches are issued one per cycle and a busy flag holds the pipeline. A commit or a redefinition of the register frees its entry. A registered full flag tells the issue logic that the next new preload must wait. The register file and the per-register ready, freeze and preload state stay outside this block.

Top module: `preload_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every entry becomes invalid. After that edge `full`, `busy` and `patch_valid` read 0, and no store produces a patch until an entry is allocated.
- R2: A preload for a register that owns no entry goes into the free entry with the lowest index. Entry index determines the order of patches for a multi-match store (R7).
- R3: A preload for a register that already owns a valid entry overwrites that entry's address and takes no further entry. The old address then no longer matches.
- R4: `full` reads 1 from the cycle after all entries are valid. A preload to an untracked register while `full` is 1 is dropped, and its address does not match later stores.
- R5: A store whose address equals the address of exactly one valid entry gives `patch_valid`=1 in the next cycle. `patch_reg` then holds that entry's register and `patch_data` holds the store data, with `busy`=0.
- R6: A store whose address matches no valid entry leaves `patch_valid` at 0.
- R7: A store that matches k>1 entries gives k consecutive patch cycles, starting the cycle after the store, in ascending entry order. `busy` is 1 in every patch cycle except the last.
- R8: A release names a register. It invalidates the entry whose pointer equals that register, so later stores to its address are not patched and `full` drops in the next cycle.
- R9: A release of a register that owns no entry changes nothing: `full` and the matches seen by later stores are unaffected.
- R10: An entry stays valid after a matching store and keeps matching later stores until it is released.
- R11: If a preload and a release for the same register arrive in the same cycle, the preload wins. The entry stays valid with the new address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | A preload executes this cycle |
| alloc_reg | input | REG_W | Destination register of the preload |
| alloc_addr | input | ADDR_W | Memory address of the preload |
| store_valid | input | 1 | A store executes this cycle |
| store_addr | input | ADDR_W | Store address |
| store_data | input | DATA_W | Store data |
| release_valid | input | 1 | Commit or redefinition of a register this cycle |
| release_reg | input | REG_W | Register whose tracking ends |
| full | output | 1 | All entries in use; a new preload must wait |
| busy | output | 1 | More patches from the last store are pending |
| patch_valid | output | 1 | A register patch is presented this cycle |
| patch_reg | output | REG_W | Register to overwrite |
| patch_data | output | DATA_W | Value to write into that register |

## Verification
The assertions assume the pipeline is frozen while `busy` is 1. In that state no store, preload or release arrives, so the entries and the pending match set cannot change during a drain. They also assume that the issue logic never presents a new-register preload while `full` is 1 and expects it to be kept. The directed stimulus waits for `busy` to clear before driving anything new. The only preload sent while `full` is 1 is there on purpose, to show that it is dropped. No two valid entries may ever name the same register. This holds because every preload first looks for its register's existing entry, and the stimulus includes a repeated preload to test that lookup.

// File: rtl/pt_pkg.sv
package pt_pkg;
  localparam int unsigned PT_NUM_REGS    = 32;
  localparam int unsigned PT_NUM_ENTRIES = 4;
  localparam int unsigned PT_ADDR_W      = 32;
  localparam int unsigned PT_DATA_W      = 32;

  function automatic int unsigned pt_idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/pt_lowest.sv
module pt_lowest #(
  parameter int unsigned W  = 4,
  parameter int unsigned IW = 2
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [W-1:0]  onehot
);
  always_comb begin
    found  = 1'b0;
    idx    = '0;
    onehot = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found  = 1'b1;
        idx    = IW'(i);
        onehot = W'(1) << i;
      end
    end
  end
endmodule

// File: rtl/pt_entry_array.sv
module pt_entry_array #(
  parameter int unsigned M      = 4,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IW     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [IW-1:0]           wr_idx,
  input  logic [REG_W-1:0]        wr_reg,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [M-1:0]            clr_vec,
  input  logic                    st_valid,
  input  logic [ADDR_W-1:0]       st_addr,
  input  logic [REG_W-1:0]        lk_reg,
  input  logic                    rel_valid,
  input  logic [REG_W-1:0]        rel_reg,
  output logic [M-1:0]            valid_vec,
  output logic [M-1:0][REG_W-1:0] reg_vec,
  output logic [M-1:0]            st_hit,
  output logic [M-1:0]            lk_hit,
  output logic [M-1:0]            rel_hit,
  output logic                    all_valid
);
  logic [M-1:0]             valid_q;
  logic [M-1:0][REG_W-1:0]  reg_q;
  logic [M-1:0][ADDR_W-1:0] addr_q;
  logic [M-1:0]             wr_oh;
  logic [M-1:0]             valid_d;
  logic                     all_q;

  always_comb begin
    wr_oh   = wr_en ? (M'(1) << wr_idx) : '0;
    valid_d = (valid_q & ~clr_vec) | wr_oh;
  end

  generate
    for (genvar e = 0; e < M; e++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          valid_q[e] <= 1'b0;
          reg_q[e]   <= '0;
          addr_q[e]  <= '0;
        end else begin
          valid_q[e] <= valid_d[e];
          if (wr_oh[e]) begin
            reg_q[e]  <= wr_reg;
            addr_q[e] <= wr_addr;
          end
        end
      end
      assign st_hit[e]  = st_valid && valid_q[e] && (addr_q[e] == st_addr);
      assign lk_hit[e]  = valid_q[e] && (reg_q[e] == lk_reg);
      assign rel_hit[e] = rel_valid && valid_q[e] && (reg_q[e] == rel_reg);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) all_q <= 1'b0;
    else     all_q <= &valid_d;
  end

  assign valid_vec = valid_q;
  assign reg_vec   = reg_q;
  assign all_valid = all_q;

  // Two valid entries must never protect the same register.
  logic dup_reg;
  always_comb begin
    dup_reg = 1'b0;
    for (int a = 0; a < M; a++)
      for (int b = a + 1; b < M; b++)
        if (valid_q[a] && valid_q[b] && reg_q[a] == reg_q[b]) dup_reg = 1'b1;
  end

  p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
    !dup_reg);

  // A fresh allocation must land on an entry that was free.
  p_alloc_to_free_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(|lk_hit)) |-> !valid_q[wr_idx]);
endmodule

// File: rtl/pt_patch_seq.sv
module pt_patch_seq #(
  parameter int unsigned M      = 4,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IW     = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    st_valid,
  input  logic [DATA_W-1:0]       st_data,
  input  logic [M-1:0]            st_hit,
  input  logic [M-1:0][REG_W-1:0] reg_vec,
  output logic                    patch_valid,
  output logic [REG_W-1:0]        patch_reg,
  output logic [DATA_W-1:0]       patch_data,
  output logic                    busy
);
  logic [M-1:0]        pending_q;
  logic                busy_q;
  logic                pv_q;
  logic [REG_W-1:0]    preg_q;
  logic [DATA_W-1:0]   pdata_q;
  logic [M-1:0]        src;
  logic                src_found;
  logic [IW-1:0]       src_idx;
  logic [M-1:0]        src_oh;
  logic [M-1:0]        rest;

  assign src  = busy_q ? pending_q : st_hit;
  assign rest = src & ~src_oh;

  pt_lowest #(.W(M), .IW(IW)) u_pick (
    .vec    (src),
    .found  (src_found),
    .idx    (src_idx),
    .onehot (src_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= '0;
      busy_q    <= 1'b0;
      pv_q      <= 1'b0;
      preg_q    <= '0;
      pdata_q   <= '0;
    end else begin
      pending_q <= rest;
      busy_q    <= |rest;
      pv_q      <= src_found;
      if (src_found) preg_q <= reg_vec[src_idx];
      if (!busy_q)   pdata_q <= st_data;
    end
  end

  assign patch_valid = pv_q;
  assign patch_reg   = preg_q;
  assign patch_data  = pdata_q;
  assign busy        = busy_q;

  p_busy_has_patch_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> pv_q);

  p_store_held_off_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |-> !st_valid);

  p_drain_shrinks_r7: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($countones(pending_q) < $past($countones(pending_q))));
endmodule

// File: rtl/preload_tracker.sv
module preload_tracker
  import pt_pkg::*;
#(
  parameter int unsigned NUM_REGS    = PT_NUM_REGS,
  parameter int unsigned NUM_ENTRIES = PT_NUM_ENTRIES,
  parameter int unsigned ADDR_W      = PT_ADDR_W,
  parameter int unsigned DATA_W      = PT_DATA_W,
  localparam int unsigned REG_W      = pt_idx_w(NUM_REGS),
  localparam int unsigned IDX_W      = pt_idx_w(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  input  logic [REG_W-1:0]  alloc_reg,
  input  logic [ADDR_W-1:0] alloc_addr,
  input  logic              store_valid,
  input  logic [ADDR_W-1:0] store_addr,
  input  logic [DATA_W-1:0] store_data,
  input  logic              release_valid,
  input  logic [REG_W-1:0]  release_reg,
  output logic              full,
  output logic              busy,
  output logic              patch_valid,
  output logic [REG_W-1:0]  patch_reg,
  output logic [DATA_W-1:0] patch_data
);
  localparam int unsigned M = NUM_ENTRIES;

  logic [M-1:0]            valid_vec;
  logic [M-1:0][REG_W-1:0] reg_vec;
  logic [M-1:0]            st_hit;
  logic [M-1:0]            lk_hit;
  logic [M-1:0]            rel_hit;
  logic                    all_valid;

  logic             own_found;
  logic [IDX_W-1:0] own_idx;
  logic [M-1:0]     own_oh;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic [M-1:0]     free_oh;

  logic             alloc_go;
  logic [IDX_W-1:0] wr_idx;
  logic [M-1:0]     wr_oh;
  logic [M-1:0]     clr_vec;

  pt_lowest #(.W(M), .IW(IDX_W)) u_own (
    .vec    (lk_hit),
    .found  (own_found),
    .idx    (own_idx),
    .onehot (own_oh)
  );

  pt_lowest #(.W(M), .IW(IDX_W)) u_free (
    .vec    (~valid_vec),
    .found  (free_found),
    .idx    (free_idx),
    .onehot (free_oh)
  );

  always_comb begin
    alloc_go = alloc_valid && (own_found || free_found);
    wr_idx   = own_found ? own_idx : free_idx;
    wr_oh    = alloc_go ? (own_found ? own_oh : free_oh) : '0;
    clr_vec  = rel_hit & ~wr_oh;
  end

  pt_entry_array #(.M(M), .REG_W(REG_W), .ADDR_W(ADDR_W), .IW(IDX_W)) u_entries (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (alloc_go),
    .wr_idx    (wr_idx),
    .wr_reg    (alloc_reg),
    .wr_addr   (alloc_addr),
    .clr_vec   (clr_vec),
    .st_valid  (store_valid),
    .st_addr   (store_addr),
    .lk_reg    (alloc_reg),
    .rel_valid (release_valid),
    .rel_reg   (release_reg),
    .valid_vec (valid_vec),
    .reg_vec   (reg_vec),
    .st_hit    (st_hit),
    .lk_hit    (lk_hit),
    .rel_hit   (rel_hit),
    .all_valid (all_valid)
  );

  pt_patch_seq #(.M(M), .REG_W(REG_W), .DATA_W(DATA_W), .IW(IDX_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .st_valid    (store_valid),
    .st_data     (store_data),
    .st_hit      (st_hit),
    .reg_vec     (reg_vec),
    .patch_valid (patch_valid),
    .patch_reg   (patch_reg),
    .patch_data  (patch_data),
    .busy        (busy)
  );

  assign full = all_valid;

  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (!full && !busy && !patch_valid));

  p_full_drops_new_r4: assert property (@(posedge clk) disable iff (rst)
    (full && alloc_valid && !own_found && !release_valid) |=> full);

  p_release_frees_r8: assert property (@(posedge clk) disable iff (rst)
    (release_valid && (|rel_hit) && !alloc_valid) |=> !full);
endmodule

// File: tb/preload_tracker_tb.sv
module preload_tracker_tb;
  localparam int CLK_P  = 10;
  localparam int REG_W  = 5;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int WATCHDOG_CYC = 20000;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              alloc_valid = 1'b0;
  logic [REG_W-1:0]  alloc_reg = '0;
  logic [ADDR_W-1:0] alloc_addr = '0;
  logic              store_valid = 1'b0;
  logic [ADDR_W-1:0] store_addr = '0;
  logic [DATA_W-1:0] store_data = '0;
  logic              release_valid = 1'b0;
  logic [REG_W-1:0]  release_reg = '0;
  logic              full;
  logic              busy;
  logic              patch_valid;
  logic [REG_W-1:0]  patch_reg;
  logic [DATA_W-1:0] patch_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  preload_tracker u_dut (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_reg(alloc_reg), .alloc_addr(alloc_addr),
    .store_valid(store_valid), .store_addr(store_addr), .store_data(store_data),
    .release_valid(release_valid), .release_reg(release_reg),
    .full(full), .busy(busy), .patch_valid(patch_valid),
    .patch_reg(patch_reg), .patch_data(patch_data)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_alloc(input logic [REG_W-1:0] r, input logic [ADDR_W-1:0] a);
    alloc_valid = 1'b1; alloc_reg = r; alloc_addr = a;
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_release(input logic [REG_W-1:0] r);
    release_valid = 1'b1; release_reg = r;
    @(negedge clk);
    release_valid = 1'b0;
  endtask

  // Issue a store and check n patches in order, then a quiet cycle.
  task automatic store_check(input string req, input logic [ADDR_W-1:0] a,
                             input logic [DATA_W-1:0] d, input int n,
                             input logic [4*REG_W-1:0] regs);
    store_valid = 1'b1; store_addr = a; store_data = d;
    @(negedge clk);
    store_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      check(req, "patch_valid", 32'(patch_valid), 32'd1);
      check(req, "patch_reg",   32'(patch_reg),   32'(regs[k*REG_W +: REG_W]));
      check(req, "patch_data",  patch_data,       d);
      check(req, "busy",        32'(busy),        32'(k < n - 1));
      @(negedge clk);
    end
    check(req, "patch_valid idle", 32'(patch_valid), 32'd0);
    check(req, "busy idle",        32'(busy),        32'd0);
  endtask

  function automatic logic [4*REG_W-1:0] rl(input int a, input int b, input int c, input int d);
    return {REG_W'(d), REG_W'(c), REG_W'(b), REG_W'(a)};
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    idle(); idle();
    rst = 1'b0;
    idle();
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "full",        32'(full),        32'd0);
    check("R1", "busy",        32'(busy),        32'd0);
    check("R1", "patch_valid", 32'(patch_valid), 32'd0);
    store_check("R1", 32'h0, 32'h1234, 0, '0);
  endtask

  task automatic t_single();
    do_reset();
    do_alloc(5'd5, 32'h100);
    store_check("R5", 32'h100, 32'hAA55_0001, 1, rl(5, 0, 0, 0));
    store_check("R6", 32'h104, 32'h0000_0002, 0, '0);
    store_check("R10", 32'h100, 32'hBEEF_0003, 1, rl(5, 0, 0, 0));
    do_release(5'd5);
    store_check("R8", 32'h100, 32'h0000_0004, 0, '0);
  endtask

  task automatic t_multi_full();
    do_reset();
    do_alloc(5'd7, 32'h200);
    do_alloc(5'd3, 32'h200);
    do_alloc(5'd9, 32'h300);
    check("R4", "full before last", 32'(full), 32'd0);
    do_alloc(5'd1, 32'h200);
    check("R4", "full", 32'(full), 32'd1);
    store_check("R7", 32'h200, 32'h7777_0000, 3, rl(7, 3, 1, 0));
    do_alloc(5'd20, 32'h200);
    check("R4", "full after drop", 32'(full), 32'd1);
    store_check("R4", 32'h200, 32'h7777_0001, 3, rl(7, 3, 1, 0));
    do_release(5'd7);
    check("R8", "full after release", 32'(full), 32'd0);
    do_release(5'd9);
    do_alloc(5'd20, 32'h200);
    store_check("R2", 32'h200, 32'h2222_0002, 3, rl(20, 3, 1, 0));
  endtask

  task automatic t_reuse();
    do_reset();
    do_alloc(5'd4, 32'h400);
    do_alloc(5'd4, 32'h500);
    store_check("R3", 32'h400, 32'h0000_0010, 0, '0);
    store_check("R3", 32'h500, 32'h0000_0011, 1, rl(4, 0, 0, 0));
    do_alloc(5'd10, 32'h600);
    do_alloc(5'd11, 32'h700);
    check("R3", "full with three regs", 32'(full), 32'd0);
    do_alloc(5'd12, 32'h800);
    check("R3", "full with four regs", 32'(full), 32'd1);
  endtask

  task automatic t_release_untracked();
    do_release(5'd30);
    check("R9", "full", 32'(full), 32'd1);
    store_check("R9", 32'h500, 32'h0000_0020, 1, rl(4, 0, 0, 0));
  endtask

  task automatic t_same_cycle();
    alloc_valid = 1'b1; alloc_reg = 5'd4; alloc_addr = 32'h900;
    release_valid = 1'b1; release_reg = 5'd4;
    @(negedge clk);
    alloc_valid = 1'b0; release_valid = 1'b0;
    check("R11", "full", 32'(full), 32'd1);
    store_check("R11", 32'h900, 32'h0000_0030, 1, rl(4, 0, 0, 0));
    store_check("R11", 32'h500, 32'h0000_0031, 0, '0);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_single();
    t_multi_full();
    t_reuse();
    t_release_untracked();
    t_same_cycle();
    idle();
    report();
  end

  initial begin
    for (int c = 0; c < WATCHDOG_CYC; c++) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule